// File: doc/BRIEF.md
# Expandable Multiplexed Segment Display Controller

This block stores four 8-bit segment patterns, one per digit of a multiplexed LED display, and shows them one digit at a time. Every bit maps to one segment, so the host controls each segment directly. The host writes through a low-active chip-select and write-strobe pair with a 2-bit digit address. The port behaves like a small asynchronous RAM. The controller samples it with synchronizers, and the write takes effect when the access window closes.

When it runs as master, an internal sequencer derives a digit-advance tick from the system clock. It raises one digit strobe at a time, in ascending order, and leaves a dark gap between strobes. When it runs as slave, the digit lines become inputs and the sequencer stops. An external controller then picks which register reaches the segment pins, which lets several devices share one scan and drive wider segment groups.

The segment drivers have a separate output enable. Disabling the segments in slave mode with no digit selected puts the block in a quiet state.

Top module: `segdisp_ctrl`

## Requirements
- R1: A completed write stores `data` in the register picked by `addr`. The value 0 selects digit 1, 1 selects digit 2, 2 selects digit 3 and 3 selects digit 4. In slave mode, driving only `dig_in[i]` high shows digit i+1 on `seg_o`, with bit i of `dig_in` standing for digit i+1. All registers read zero after reset.
- R2: A register does not change while `ce_n` and `we_n` are both low. The write commits once either of them goes high, using the address and data present before that rising edge. Changing `addr` or `data` in the same cycle as that edge does not alter the stored value.
- R3: While `ce_n` is high, pulses on `we_n` leave every register unchanged.
- R4: `seg_oe` is high when `soe_n` is low and low when `soe_n` is high.
- R5: In master mode (`dir_slave` low), all four `dig_oe` bits are high and at most one `dig_o` bit is high. Strobes follow digit 1, 2, 3, 4 and then wrap. The first strobe after the block leaves slave mode is digit 1.
- R6: In master mode, each strobe lasts SLOT-BLANK_CYCLES clocks and is followed by BLANK_CYCLES clocks with every digit line low, where SLOT is CLK_HZ/(4*SCAN_HZ). `seg_o` is zero during these gaps.
- R7: In master mode, while a digit strobe is high, `seg_o` equals that digit's register.
- R8: In slave mode, `dig_oe` and `dig_o` are all zero and the sequencer is halted.
- R9: In slave mode, when more than one `dig_in` bit is high, the lowest-numbered digit is shown. When none is high, `seg_o` is zero.
- R10: `quiescent` is high exactly when `soe_n` is high, `dir_slave` is high and `dig_in` is zero. While it is high, `seg_o`, `dig_o` and `seg_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 2 | Digit address of the write |
| data | input | 8 | Segment pattern to write |
| soe_n | input | 1 | Segment output enable, active low |
| dir_slave | input | 1 | High: digit lines are inputs (slave mode) |
| dig_in | input | 4 | Digit select from an external master |
| seg_o | output | 8 | Segment values |
| seg_oe | output | 1 | Segment driver enable |
| dig_o | output | 4 | Digit strobes, active high |
| dig_oe | output | 4 | Digit line driver enables |
| quiescent | output | 1 | Power-saver state indicator |

## Verification
Two things can land in the same cycle: a host write committing and the sequencer presenting the digit being written. This is provoked by running the scan in master mode while a concurrent thread issues random writes. Half of those writes close on chip select and half on the write strobe, and the address and data change right at the closing edge. The monitor compares every strobe against the bench's register model and skips only the few cycles in which a write is in flight. Each stored value is read back afterwards in slave mode to confirm that the pre-edge data was captured.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int NDIG   = 4;
  localparam int SEG_W  = 8;
  localparam int ADDR_W = $clog2(NDIG);

  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [ADDR_W-1:0] dsel_t;

  // lowest-numbered set bit wins
  function automatic dsel_t lowest_set(input logic [NDIG-1:0] v);
    dsel_t r;
    r = '0;
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (v[i]) r = dsel_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/segdisp_wrport.sv
module segdisp_wrport
  import segdisp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n,
  input  logic  we_n,
  input  dsel_t addr,
  input  seg_t  data,
  output logic  wr_go,
  output dsel_t wr_addr,
  output seg_t  wr_data
);
  logic [1:0] ce_q, we_q;
  dsel_t      a_q1, a_q2, hold_a;
  seg_t       d_q1, d_q2, hold_d;
  logic       open_q;
  logic       closed_s;
  logic       hold_en;

  always_comb begin
    closed_s = ce_q[1] | we_q[1];
    hold_en  = ~closed_s;
    wr_go    = open_q & closed_s;
    wr_addr  = hold_a;
    wr_data  = hold_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 2'b11;
      we_q   <= 2'b11;
      a_q1   <= '0;
      a_q2   <= '0;
      d_q1   <= '0;
      d_q2   <= '0;
      open_q <= 1'b0;
    end else begin
      ce_q   <= {ce_q[0], ce_n};
      we_q   <= {we_q[0], we_n};
      a_q1   <= addr;
      a_q2   <= a_q1;
      d_q1   <= data;
      d_q2   <= d_q1;
      open_q <= ~closed_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_d <= '0;
    end else if (hold_en) begin
      hold_a <= a_q2;
      hold_d <= d_q2;
    end
  end
endmodule

// File: rtl/segdisp_scan.sv
module segdisp_scan
  import segdisp_pkg::*;
#(
  parameter int SLOT_CYC  = 31250,
  parameter int BLANK_CYC = 400
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  halt,
  output dsel_t idx,
  output logic  strobe
);
  localparam int CNT_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] BLK  = CNT_W'(BLANK_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  dsel_t            idx_q, idx_nx;

  always_comb begin
    cnt_nx = cnt_q;
    idx_nx = idx_q;
    if (halt) begin
      cnt_nx = '0;
      idx_nx = '0;
    end else if (cnt_q == LAST) begin
      cnt_nx = '0;
      idx_nx = idx_q + dsel_t'(1);
    end else begin
      cnt_nx = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      idx_q <= idx_nx;
    end
  end

  assign idx    = idx_q;
  assign strobe = ~halt & (cnt_q >= BLK);
endmodule

// File: rtl/segdisp_segmux.sv
module segdisp_segmux
  import segdisp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_go,
  input  dsel_t           wr_addr,
  input  seg_t            wr_data,
  input  logic            slave,
  input  logic [NDIG-1:0] dig_in,
  input  dsel_t           scan_idx,
  input  logic            scan_on,
  output seg_t            seg_val
);
  seg_t regs [NDIG];

  for (genvar g = 0; g < NDIG; g++) begin : g_reg
    logic en;
    assign en = wr_go & (wr_addr == dsel_t'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[g] <= '0;
      else if (en) regs[g] <= wr_data;
    end
  end

  always_comb begin
    seg_val = '0;
    if (slave) begin
      if (|dig_in) seg_val = regs[lowest_set(dig_in)];
    end else if (scan_on) begin
      seg_val = regs[scan_idx];
    end
  end
endmodule

// File: rtl/segdisp_ctrl.sv
module segdisp_ctrl
  import segdisp_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int SCAN_HZ      = 400,
  parameter int BLANK_CYCLES = 400   // must be at least 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic [1:0]      addr,
  input  logic [7:0]      data,
  input  logic            soe_n,
  input  logic            dir_slave,
  input  logic [3:0]      dig_in,
  output logic [7:0]      seg_o,
  output logic            seg_oe,
  output logic [3:0]      dig_o,
  output logic [3:0]      dig_oe,
  output logic            quiescent
);
  localparam int SLOT_CYC = CLK_HZ / (SCAN_HZ * NDIG);

  logic [1:0] rst_q;
  logic       rst_core_n;
  logic       wr_go;
  dsel_t      wr_addr;
  seg_t       wr_data;
  dsel_t      scan_idx;
  logic       scan_on;
  seg_t       seg_val;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  segdisp_wrport u_wr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .addr    (addr),
    .data    (data),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  segdisp_scan #(
    .SLOT_CYC  (SLOT_CYC),
    .BLANK_CYC (BLANK_CYCLES)
  ) u_scan (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .halt   (dir_slave),
    .idx    (scan_idx),
    .strobe (scan_on)
  );

  segdisp_segmux u_mux (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_go    (wr_go),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .slave    (dir_slave),
    .dig_in   (dig_in),
    .scan_idx (scan_idx),
    .scan_on  (scan_on),
    .seg_val  (seg_val)
  );

  always_comb begin
    quiescent = soe_n & dir_slave & ~(|dig_in);
    seg_o     = seg_val;
    seg_oe    = ~soe_n;
    dig_oe    = {NDIG{~dir_slave}};
    dig_o     = '0;
    if (!dir_slave && scan_on) dig_o[scan_idx] = 1'b1;
  end
endmodule

// File: rtl/segdisp_ctrl_chk.sv
module segdisp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_slave,
  input logic [7:0] seg_o,
  input logic       seg_oe,
  input logic [3:0] dig_o,
  input logic [3:0] dig_oe,
  input logic       quiescent
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_o)); // R5

  AST_SLAVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_slave |-> (dig_oe == 4'h0 && dig_o == 4'h0)); // R8

  AST_GAP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_slave && dig_o == 4'h0) |-> seg_o == 8'h00); // R6

  AST_STROBE_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_slave && $past(!dir_slave) && dig_o != 4'h0 && $past(dig_o) != 4'h0)
      |-> dig_o == $past(dig_o)); // R6

  AST_QUIET_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    quiescent |-> (!seg_oe && dig_o == 4'h0 && seg_o == 8'h00)); // R10
endmodule

bind segdisp_ctrl segdisp_ctrl_chk u_chk (.*);

// File: tb/segdisp_ctrl_test.sv
module segdisp_ctrl_test;
  localparam int CLK_HZ = 800;
  localparam int SCAN_HZ = 20;
  localparam int BLANK = 3;
  localparam int SLOT = CLK_HZ / (SCAN_HZ * 4);
  localparam int RUN = SLOT - BLANK;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ce_n, we_n, soe_n, dir_slave, seg_oe, quiescent;
  logic [1:0] addr;
  logic [7:0] data, seg_o;
  logic [3:0] dig_in, dig_o, dig_oe;

  segdisp_ctrl #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ), .BLANK_CYCLES(BLANK)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .data(data),
    .soe_n(soe_n), .dir_slave(dir_slave), .dig_in(dig_in), .seg_o(seg_o),
    .seg_oe(seg_oe), .dig_o(dig_o), .dig_oe(dig_oe), .quiescent(quiescent));

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [4];
  bit busy = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_slave(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return mdl[i];
    return 8'h00;
  endfunction

  function automatic int low_of(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic do_write(input logic [1:0] a, input logic [7:0] d, input bit close_ce);
    @(negedge clk); addr = a; data = d; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk);
    if (close_ce) ce_n = 1'b1; else we_n = 1'b1;
    busy = 1;
    addr = 2'($urandom); data = 8'($urandom);  // no hold after the edge
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (5) @(negedge clk);
    mdl[a] = d;
    busy = 0;
  endtask

  task automatic read_chk(input int d, input string req);
    @(negedge clk); dir_slave = 1'b1; dig_in = 4'(1 << d);
    #2 chk(req, seg_o, mdl[d]);
  endtask

  task automatic monitor(input int n);
    int last = -1;
    int run = 0;
    int gap = 0;
    bit in_st = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #2;
      chk("R5 dig_oe", dig_oe, 4'hF);
      if (dig_o == 4'h0) begin
        if (in_st) begin
          chk("R6 strobe length", run, RUN);
          in_st = 0;
          gap = 0;
        end
        gap++;
        chk("R6 dark gap segments", seg_o, 8'h00);
      end else begin
        int ix;
        chk("R5 single strobe", $countones(dig_o), 1);
        ix = low_of(dig_o);
        if (!in_st) begin
          if (last < 0) chk("R5 first strobe digit1", ix, 0);
          else begin
            chk("R5 scan order", ix, (last + 1) % 4);
            chk("R6 gap length", gap, BLANK);
          end
          last = ix;
          in_st = 1;
          run = 0;
        end
        run++;
        if (!busy) chk("R7 strobe segments", seg_o, mdl[ix]);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    rst_n = 0; ce_n = 1; we_n = 1; soe_n = 0; dir_slave = 1;
    dig_in = 0; addr = 0; data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    #2;
    chk("R8 reset dig_oe", dig_oe, 4'h0);
    chk("R8 reset dig_o", dig_o, 4'h0);
    chk("R4 seg_oe on", seg_oe, 1'b1);
    for (int d = 0; d < 4; d++) read_chk(d, "R1 reset zero");

    // directed writes, one per address
    do_write(2'd0, 8'h3F, 0);
    do_write(2'd1, 8'h06, 1);
    do_write(2'd2, 8'h5B, 0);
    do_write(2'd3, 8'hCF, 1);
    for (int d = 0; d < 4; d++) read_chk(d, "R1 addressed write");

    // window held open: no change until it closes
    @(negedge clk); dir_slave = 1; dig_in = 4'b0100;
    addr = 2'd2; data = 8'hAA; ce_n = 0; we_n = 0;
    repeat (6) @(negedge clk);
    #2 chk("R2 open window holds", seg_o, mdl[2]);
    @(negedge clk); we_n = 1; data = 8'h11; addr = 2'd0;
    repeat (5) @(negedge clk);
    ce_n = 1;
    mdl[2] = 8'hAA;
    #2 chk("R2 commit pre-edge data", seg_o, 8'hAA);
    read_chk(0, "R2 no spill to other address");

    // chip select high blocks writes
    @(negedge clk); ce_n = 1; addr = 2'd1; data = 8'h55;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); we_n = 0;
      repeat (3) @(negedge clk); we_n = 1;
    end
    repeat (5) @(negedge clk);
    for (int d = 0; d < 4; d++) read_chk(d, "R3 ce high no write");

    // slave priority, random selects
    for (int k = 0; k < 20; k++) begin
      logic [3:0] v;
      v = (k == 0) ? 4'b0000 : ((k == 1) ? 4'b1111 : 4'($urandom));
      @(negedge clk); dir_slave = 1; dig_in = v;
      #2 chk("R9 slave select", seg_o, exp_slave(v));
      chk("R8 slave no drive", {dig_oe, dig_o}, 8'h00);
    end

    // output enable and quiet state
    for (int k = 0; k < 8; k++) begin
      logic s, dv;
      logic [3:0] v;
      s = k[0]; dv = k[1]; v = k[2] ? 4'($urandom | 1) : 4'h0;
      @(negedge clk); soe_n = s; dir_slave = dv; dig_in = v;
      #2 chk("R4 seg_oe", seg_oe, !s);
      chk("R10 quiescent", quiescent, s & dv & (v == 0));
      if (s & dv & (v == 0)) chk("R10 dark", {seg_o, dig_o}, 12'h000);
    end

    // master scan with concurrent writes
    @(negedge clk); soe_n = 0; dig_in = 0; dir_slave = 0;
    fork
      monitor(600);
      begin
        repeat (30) @(negedge clk);
        for (int k = 0; k < 12; k++) begin
          do_write(2'($urandom), 8'($urandom), bit'(k % 2));
          repeat (5 + ($urandom % 9)) @(negedge clk);
        end
      end
    join

    for (int d = 0; d < 4; d++) read_chk(d, "R1 R2 readback after scan writes");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule